// File: doc/BRIEF.md
# Hardware/Software Cross-Call Controller

This block schedules calls between a host processor and a set of hardware function units. The processor can start a unit, and a running unit can call a software routine on the processor, call another unit, or call itself. The controller keeps a stack of caller records so that each finish returns control to the right party: the processor (by interrupt) or the unit that made the call (by re-enabling it). Only one unit runs at any time.

The processor talks to the block through a small register port. Addresses 0 to 6 hold the shared call registers: argument words 0 to 3, stack pointer, link and return value. The command addresses are 8 (start a unit, with the unit number in the write data), 9 (software routine finished, with the write data as return value) and 10 (acknowledge interrupt). Address 11 reads the status word. The running unit writes the same call registers through a shared write port, and every unit sees their current values on output buses. Arguments beyond the fourth travel on a memory stack that lies outside this block.

Each call pushes one record: whether the caller is software or a unit, the unit number, and the link register value at the moment of the call. Each finish pops the top record. The link register is then restored from that record, and control goes back to the caller it names.

Top module: `cross_call_ctrl`

## Requirements
- R1: After reset no unit is enabled, the interrupt is low, and the status word and every call register read as zero.
- R2: While no unit runs (states IDLE or HOST_RUN), a write of a unit number below NUM_UNITS to address 8 enables exactly that unit from the next clock edge. No interrupt is raised.
- R3: When a unit whose top caller record is software asserts finish, the next cycle has all enables low and the interrupt high. Status bits [2:1] read 01 and bit 0 reads 1, and the link register is restored from the record. The state goes to IDLE if the stack is then empty and to HOST_RUN otherwise.
- R4: When the running unit asserts call with its software flag set, the next cycle has all enables low and the interrupt high. Status bits [2:1] read 10, and status bits [15:8] hold the software routine number taken from the unit's target field.
- R5: In HOST_RUN, a write to address 9 loads the write data into the return-value register, restores the link register from the popped record, and enables the unit named in that record from the next edge.
- R6: A call from the running unit with the software flag clear and a target below NUM_UNITS enables the target one cycle after the request (well under 5 cycles). It drops the caller's enable and raises no interrupt.
- R7: When a unit called by another unit finishes, the caller is enabled again on the next cycle. The return value written by the callee stays visible, and the link register is restored to the caller's value at the time of its call.
- R8: Once raised, the interrupt stays high until the host writes address 10. That write clears status bit 0 and leaves the cause and routine-number fields unchanged.
- R9: The caller stack holds 16 records. A call that would push a 17th sets status bit 3. That flag stays set until reset, the call is not serviced, and the enables are unchanged.
- R10: Nested and recursive calls, including a unit calling itself up to the stack depth, unwind in reverse order, and each finish restores the link value that was pushed by the matching call.
- R11: At most one unit enable is high in any cycle.
- R12: Call and finish requests from units that are not running are ignored. A write to address 9 is ignored unless the state is HOST_RUN, and a write to address 8 is ignored while a unit runs.
- R13: Call registers 0..6 (args 0-3, SP, LR, return value) can be written by the host and read back at the same addresses. The unit write port takes effect only while a unit runs, and wins over a host write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address (read and write) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| host_irq | output | 1 | Interrupt to the processor |
| unit_en | output | NUM_UNITS | Per-unit run enable |
| unit_call | input | NUM_UNITS | Per-unit call request |
| unit_call_sw | input | NUM_UNITS | Per-unit call target is a software routine |
| unit_target | input | NUM_UNITS*SWID_W | Per-unit target: unit number or software routine number |
| unit_finish | input | NUM_UNITS | Per-unit finish strobe |
| unit_reg_we | input | 1 | Running unit writes a call register |
| unit_reg_sel | input | 3 | Call register index 0..6 |
| unit_reg_wdata | input | DATA_W | Running unit write data |
| call_args | output | 4*DATA_W | Argument words 0..3, word 0 in the low bits |
| call_sp | output | DATA_W | Shared stack pointer |
| call_lr | output | DATA_W | Link register |
| call_ret | output | DATA_W | Return-value register |

## Verification
The bench goes after the return path. It checks that a unit-to-unit finish resumes the caller rather than interrupting the host, and that a finish under a software record raises the interrupt. A design that confused the two would either stall a caller or wake the processor spuriously. The bench fills the stack to exactly 16 records with self-calls, each with a distinct link value, then attempts one more and unwinds. An off-by-one depth would overflow early or late, and a wrong restore order would show a link value out of sequence. It also sends requests from idle units, a routine-finished write outside HOST_RUN and a unit write while no unit runs, and confirms these leave enables and registers untouched.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_UNIT_RUN = 2'd1,
        ST_HOST_RUN = 2'd2
    } cc_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_HW_DONE = 2'd1,
        CAUSE_SW_REQ  = 2'd2
    } cc_cause_e;

    localparam int CC_NUM_ARGS = 4;
    localparam int CC_NUM_REGS = CC_NUM_ARGS + 3;
    localparam int CC_SP_IDX   = CC_NUM_ARGS;
    localparam int CC_LR_IDX   = CC_NUM_ARGS + 1;
    localparam int CC_RET_IDX  = CC_NUM_ARGS + 2;

    localparam logic [3:0] ADDR_CALL   = 4'd8;
    localparam logic [3:0] ADDR_SWDONE = 4'd9;
    localparam logic [3:0] ADDR_ACK    = 4'd10;
    localparam logic [3:0] ADDR_STATUS = 4'd11;

endpackage

// File: rtl/cc_call_regs.sv
module cc_call_regs
    import cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [2:0]                  host_sel,
    input  logic [DATA_W-1:0]           host_wdata,
    input  logic                        unit_we,
    input  logic [2:0]                  unit_sel,
    input  logic [DATA_W-1:0]           unit_wdata,
    input  logic                        lr_load,
    input  logic [DATA_W-1:0]           lr_val,
    input  logic                        ret_load,
    input  logic [DATA_W-1:0]           ret_val,
    output logic [CC_NUM_ARGS*DATA_W-1:0] args,
    output logic [DATA_W-1:0]           sp,
    output logic [DATA_W-1:0]           lr,
    output logic [DATA_W-1:0]           ret
);

    logic [DATA_W-1:0] reg_q [CC_NUM_REGS];

    for (genvar i = 0; i < CC_NUM_REGS; i++) begin : g_reg
        logic restore_hit;
        if (i == CC_LR_IDX) begin : g_lr
            assign restore_hit = lr_load;
        end else if (i == CC_RET_IDX) begin : g_ret
            assign restore_hit = ret_load;
        end else begin : g_plain
            assign restore_hit = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[i] <= '0;
            end else if (restore_hit) begin
                reg_q[i] <= (i == CC_LR_IDX) ? lr_val : ret_val;
            end else if (unit_we && unit_sel == 3'(i)) begin
                reg_q[i] <= unit_wdata;
            end else if (host_we && host_sel == 3'(i)) begin
                reg_q[i] <= host_wdata;
            end
        end
    end

    for (genvar a = 0; a < CC_NUM_ARGS; a++) begin : g_args
        assign args[a*DATA_W +: DATA_W] = reg_q[a];
    end

    assign sp  = reg_q[CC_SP_IDX];
    assign lr  = reg_q[CC_LR_IDX];
    assign ret = reg_q[CC_RET_IDX];

endmodule

// File: rtl/cc_frame_stack.sv
module cc_frame_stack #(
    parameter int ENTRY_W = 35,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [ENTRY_W-1:0] push_data,
    output logic [ENTRY_W-1:0] top_data,
    output logic               full,
    output logic               last
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]   count_q;
    logic [PTR_W-1:0]   top_idx;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign last    = (count_q == CNT_W'(1));
    assign top_idx = PTR_W'(count_q - CNT_W'(1));
    assign top_data = mem[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push && !full) begin
            count_q <= count_q + CNT_W'(1);
        end else if (pop && count_q != '0) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[PTR_W'(count_q)] <= push_data;
        end
    end

endmodule

// File: rtl/cc_irq_ctrl.sv
module cc_irq_ctrl
    import cc_pkg::*;
#(
    parameter int SWID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hw_done,
    input  logic              set_sw_req,
    input  logic [SWID_W-1:0] swid_in,
    input  logic              ack,
    output logic              irq,
    output cc_cause_e         cause,
    output logic [SWID_W-1:0] swid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            cause <= CAUSE_NONE;
            swid  <= '0;
        end else if (set_sw_req) begin
            irq   <= 1'b1;
            cause <= CAUSE_SW_REQ;
            swid  <= swid_in;
        end else if (set_hw_done) begin
            irq   <= 1'b1;
            cause <= CAUSE_HW_DONE;
        end else if (ack) begin
            irq   <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_sequencer.sv
module cc_sequencer
    import cc_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ID_W      = 2,
    parameter int SWID_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ENTRY_W   = 1 + ID_W + DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_call_cmd,
    input  logic [ID_W-1:0]             host_call_id,
    input  logic                        host_done_cmd,
    input  logic [NUM_UNITS-1:0]        unit_call,
    input  logic [NUM_UNITS-1:0]        unit_call_sw,
    input  logic [NUM_UNITS*SWID_W-1:0] unit_target,
    input  logic [NUM_UNITS-1:0]        unit_finish,
    input  logic [DATA_W-1:0]           cur_lr,
    input  logic                        stk_full,
    input  logic                        stk_last,
    input  logic [ENTRY_W-1:0]          top_entry,
    output logic [NUM_UNITS-1:0]        unit_en,
    output cc_state_e                   state,
    output logic [ID_W-1:0]             act_id,
    output logic                        ovf,
    output logic                        push,
    output logic [ENTRY_W-1:0]          push_data,
    output logic                        pop,
    output logic                        lr_restore,
    output logic                        ret_load,
    output logic                        irq_hw_done,
    output logic                        irq_sw_req,
    output logic [SWID_W-1:0]           swid
);

    cc_state_e         state_q, state_d;
    logic [ID_W-1:0]   act_q, act_d;
    logic              ovf_q, ovf_set;

    logic [SWID_W-1:0] tgt_arr [NUM_UNITS];
    logic [SWID_W-1:0] act_tgt;
    logic              act_call, act_sw, act_finish, tgt_ok;
    logic              top_sw;
    logic [ID_W-1:0]   top_id;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_tgt
        assign tgt_arr[g] = unit_target[g*SWID_W +: SWID_W];
    end

    assign act_tgt    = tgt_arr[act_q];
    assign act_call   = unit_call[act_q];
    assign act_sw     = unit_call_sw[act_q];
    assign act_finish = unit_finish[act_q];
    assign tgt_ok     = (int'(act_tgt) < NUM_UNITS);
    assign top_sw     = top_entry[ENTRY_W-1];
    assign top_id     = top_entry[DATA_W +: ID_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Next state and strobes
    always_comb begin
        state_d     = state_q;
        act_d       = act_q;
        ovf_set     = 1'b0;
        push        = 1'b0;
        push_data   = '0;
        pop         = 1'b0;
        lr_restore  = 1'b0;
        ret_load    = 1'b0;
        irq_hw_done = 1'b0;
        irq_sw_req  = 1'b0;
        swid        = act_tgt;
        unique case (state_q)
            ST_IDLE: begin
                if (host_call_cmd) begin
                    if (stk_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push      = 1'b1;
                        push_data = {1'b1, ID_W'(0), cur_lr};
                        state_d   = ST_UNIT_RUN;
                        act_d     = host_call_id;
                    end
                end
            end
            ST_HOST_RUN: begin
                if (host_call_cmd) begin
                    if (stk_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push      = 1'b1;
                        push_data = {1'b1, ID_W'(0), cur_lr};
                        state_d   = ST_UNIT_RUN;
                        act_d     = host_call_id;
                    end
                end else if (host_done_cmd) begin
                    pop        = 1'b1;
                    lr_restore = 1'b1;
                    ret_load   = 1'b1;
                    state_d    = ST_UNIT_RUN;
                    act_d      = top_id;
                end
            end
            ST_UNIT_RUN: begin
                if (act_call && (act_sw || tgt_ok)) begin
                    if (stk_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push      = 1'b1;
                        push_data = {1'b0, act_q, cur_lr};
                        if (act_sw) begin
                            irq_sw_req = 1'b1;
                            state_d    = ST_HOST_RUN;
                        end else begin
                            act_d = act_tgt[ID_W-1:0];
                        end
                    end
                end else if (act_finish) begin
                    pop        = 1'b1;
                    lr_restore = 1'b1;
                    if (top_sw) begin
                        irq_hw_done = 1'b1;
                        state_d     = stk_last ? ST_IDLE : ST_HOST_RUN;
                    end else begin
                        act_d = top_id;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unit_en = '0;
        if (state_q == ST_UNIT_RUN) begin
            unit_en[act_q] = 1'b1;
        end
    end

    assign state  = state_q;
    assign act_id = act_q;
    assign ovf    = ovf_q;

endmodule

// File: rtl/cross_call_ctrl.sv
module cross_call_ctrl
    import cc_pkg::*;
#(
    parameter int NUM_UNITS   = 4,
    parameter int DATA_W      = 32,
    parameter int SWID_W      = 8,
    parameter int STACK_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [3:0]                    host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          host_irq,
    output logic [NUM_UNITS-1:0]          unit_en,
    input  logic [NUM_UNITS-1:0]          unit_call,
    input  logic [NUM_UNITS-1:0]          unit_call_sw,
    input  logic [NUM_UNITS*SWID_W-1:0]   unit_target,
    input  logic [NUM_UNITS-1:0]          unit_finish,
    input  logic                          unit_reg_we,
    input  logic [2:0]                    unit_reg_sel,
    input  logic [DATA_W-1:0]             unit_reg_wdata,
    output logic [CC_NUM_ARGS*DATA_W-1:0] call_args,
    output logic [DATA_W-1:0]             call_sp,
    output logic [DATA_W-1:0]             call_lr,
    output logic [DATA_W-1:0]             call_ret
);

    localparam int ID_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam int ENTRY_W = 1 + ID_W + DATA_W;

    cc_state_e           seq_state;
    logic [ID_W-1:0]     seq_act;
    logic                seq_ovf;
    logic                stk_push, stk_pop, stk_full, stk_last;
    logic [ENTRY_W-1:0]  stk_push_data, stk_top;
    logic                lr_restore, ret_load;
    logic                irq_hw_done, irq_sw_req;
    logic [SWID_W-1:0]   seq_swid, irq_swid;
    cc_cause_e           irq_cause;

    logic host_reg_we, host_call_cmd, host_done_cmd, host_ack;
    logic unit_we_ok;

    assign host_reg_we   = host_we && (host_addr < 4'(CC_NUM_REGS));
    assign host_call_cmd = host_we && (host_addr == ADDR_CALL)
                           && (host_wdata < DATA_W'(NUM_UNITS));
    assign host_done_cmd = host_we && (host_addr == ADDR_SWDONE);
    assign host_ack      = host_we && (host_addr == ADDR_ACK);
    assign unit_we_ok    = unit_reg_we && (seq_state == ST_UNIT_RUN);

    cc_sequencer #(
        .NUM_UNITS (NUM_UNITS),
        .ID_W      (ID_W),
        .SWID_W    (SWID_W),
        .DATA_W    (DATA_W),
        .ENTRY_W   (ENTRY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_call_cmd(host_call_cmd),
        .host_call_id (host_wdata[ID_W-1:0]),
        .host_done_cmd(host_done_cmd),
        .unit_call    (unit_call),
        .unit_call_sw (unit_call_sw),
        .unit_target  (unit_target),
        .unit_finish  (unit_finish),
        .cur_lr       (call_lr),
        .stk_full     (stk_full),
        .stk_last     (stk_last),
        .top_entry    (stk_top),
        .unit_en      (unit_en),
        .state        (seq_state),
        .act_id       (seq_act),
        .ovf          (seq_ovf),
        .push         (stk_push),
        .push_data    (stk_push_data),
        .pop          (stk_pop),
        .lr_restore   (lr_restore),
        .ret_load     (ret_load),
        .irq_hw_done  (irq_hw_done),
        .irq_sw_req   (irq_sw_req),
        .swid         (seq_swid)
    );

    cc_frame_stack #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (STACK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_data(stk_push_data),
        .top_data (stk_top),
        .full     (stk_full),
        .last     (stk_last)
    );

    cc_call_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_reg_we),
        .host_sel   (host_addr[2:0]),
        .host_wdata (host_wdata),
        .unit_we    (unit_we_ok),
        .unit_sel   (unit_reg_sel),
        .unit_wdata (unit_reg_wdata),
        .lr_load    (lr_restore),
        .lr_val     (stk_top[DATA_W-1:0]),
        .ret_load   (ret_load),
        .ret_val    (host_wdata),
        .args       (call_args),
        .sp         (call_sp),
        .lr         (call_lr),
        .ret        (call_ret)
    );

    cc_irq_ctrl #(
        .SWID_W (SWID_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_hw_done(irq_hw_done),
        .set_sw_req (irq_sw_req),
        .swid_in    (seq_swid),
        .ack        (host_ack),
        .irq        (host_irq),
        .cause      (irq_cause),
        .swid       (irq_swid)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr < 4'(CC_NUM_ARGS)) begin
            host_rdata = call_args[host_addr[1:0]*DATA_W +: DATA_W];
        end else begin
            unique case (host_addr)
                4'(CC_SP_IDX):  host_rdata = call_sp;
                4'(CC_LR_IDX):  host_rdata = call_lr;
                4'(CC_RET_IDX): host_rdata = call_ret;
                ADDR_STATUS: begin
                    host_rdata[0]             = host_irq;
                    host_rdata[2:1]           = irq_cause;
                    host_rdata[3]             = seq_ovf;
                    host_rdata[8 +: SWID_W]   = irq_swid;
                end
                default: host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cc_checker.sv
module cc_checker
    import cc_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ID_W      = 2,
    parameter int SWID_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        host_we,
    input logic [3:0]                  host_addr,
    input logic                        host_irq,
    input logic [NUM_UNITS-1:0]        unit_en,
    input logic [NUM_UNITS-1:0]        unit_call,
    input logic [NUM_UNITS-1:0]        unit_call_sw,
    input logic [NUM_UNITS*SWID_W-1:0] unit_target,
    input logic [NUM_UNITS-1:0]        unit_finish,
    input logic [1:0]                  state,
    input logic [ID_W-1:0]             act_id,
    input logic                        stk_full,
    input logic                        top_sw,
    input logic                        ovf
);

    logic [SWID_W-1:0] tgt_c;
    logic              running, act_call, act_sw, act_fin, ack_wr;

    assign tgt_c    = unit_target[act_id*SWID_W +: SWID_W];
    assign running  = (state == ST_UNIT_RUN);
    assign act_call = running && unit_call[act_id];
    assign act_sw   = unit_call_sw[act_id];
    assign act_fin  = running && !unit_call[act_id] && unit_finish[act_id];
    assign ack_wr   = host_we && (host_addr == ADDR_ACK);

    // R11
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_en));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq && !ack_wr |=> host_irq);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9
    ovf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_call && stk_full |=> ovf && $stable(unit_en));

    // R6
    hw_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_call && !act_sw && !stk_full && (int'(tgt_c) < NUM_UNITS)
        |=> unit_en[$past(tgt_c[ID_W-1:0])] && !$rose(host_irq));

    // R4
    sw_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_call && act_sw && !stk_full |=> host_irq && (unit_en == '0));

    // R3
    hw_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fin && top_sw |=> host_irq && (unit_en == '0));

    // R7
    hw_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fin && !top_sw |=> (unit_en != '0) && !$rose(host_irq));

endmodule

bind cross_call_ctrl cc_checker #(
    .NUM_UNITS (NUM_UNITS),
    .ID_W      (ID_W),
    .SWID_W    (SWID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_irq    (host_irq),
    .unit_en     (unit_en),
    .unit_call   (unit_call),
    .unit_call_sw(unit_call_sw),
    .unit_target (unit_target),
    .unit_finish (unit_finish),
    .state       (seq_state),
    .act_id      (seq_act),
    .stk_full    (stk_full),
    .top_sw      (stk_top[ENTRY_W-1]),
    .ovf         (seq_ovf)
);

// File: tb/cross_call_ctrl_tb.sv
module cross_call_ctrl_tb;

    localparam int NU  = 4;
    localparam int DW  = 32;
    localparam int SW  = 8;

    // observation selectors
    localparam int OBS_EN  = 0;
    localparam int OBS_IRQ = 1;
    localparam int OBS_RD  = 2;
    localparam int OBS_LR  = 3;
    localparam int OBS_RET = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_we = 1'b0;
    logic [3:0]     host_addr = '0;
    logic [DW-1:0]  host_wdata = '0;
    logic [DW-1:0]  host_rdata;
    logic           host_irq;
    logic [NU-1:0]  unit_en;
    logic [NU-1:0]  unit_call = '0;
    logic [NU-1:0]  unit_call_sw = '0;
    logic [NU*SW-1:0] unit_target = '0;
    logic [NU-1:0]  unit_finish = '0;
    logic           unit_reg_we = 1'b0;
    logic [2:0]     unit_reg_sel = '0;
    logic [DW-1:0]  unit_reg_wdata = '0;
    logic [4*DW-1:0] call_args;
    logic [DW-1:0]  call_sp, call_lr, call_ret;

    cross_call_ctrl #(
        .NUM_UNITS(NU), .DATA_W(DW), .SWID_W(SW), .STACK_DEPTH(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .unit_en(unit_en), .unit_call(unit_call), .unit_call_sw(unit_call_sw),
        .unit_target(unit_target), .unit_finish(unit_finish),
        .unit_reg_we(unit_reg_we), .unit_reg_sel(unit_reg_sel),
        .unit_reg_wdata(unit_reg_wdata), .call_args(call_args),
        .call_sp(call_sp), .call_lr(call_lr), .call_ret(call_ret)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          req;
        int          sel;
        logic [31:0] exp;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            OBS_EN:  return 32'(unit_en);
            OBS_IRQ: return 32'(host_irq);
            OBS_RD:  return host_rdata;
            OBS_LR:  return call_lr;
            default: return call_ret;
        endcase
    endfunction

    // monitor: compare queued expectations
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            logic [31:0] got;
            e = q.pop_front();
            got = observe(e.sel);
            vectors++;
            if (got !== e.exp) begin
                miscompares++;
                $display("FAIL R%0d sel=%0d actual=0x%0h expected=0x%0h t=%0t",
                         e.req, e.sel, got, e.exp, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sig(int req, int sel, logic [31:0] v);
        exp_t e;
        e.req = req; e.sel = sel; e.exp = v;
        q.push_back(e);
    endtask

    task automatic expect_reg(int req, logic [3:0] a, logic [31:0] v);
        host_addr = a;
        expect_sig(req, OBS_RD, v);
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(logic [3:0] a, logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic unit_wr(int s, logic [31:0] d);
        unit_reg_we = 1'b1; unit_reg_sel = 3'(s); unit_reg_wdata = d;
        tick();
        unit_reg_we = 1'b0;
    endtask

    task automatic unit_req(int u, bit sw, int tgt);
        unit_call[u] = 1'b1;
        unit_call_sw[u] = sw;
        unit_target[u*SW +: SW] = SW'(tgt);
        tick();
        unit_call = '0;
        unit_call_sw = '0;
    endtask

    task automatic unit_done(int u);
        unit_finish[u] = 1'b1;
        tick();
        unit_finish = '0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired: actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        expect_sig(1, OBS_EN, 0);
        expect_sig(1, OBS_IRQ, 0);
        expect_reg(1, 4'd11, 0);
        expect_reg(1, 4'd5, 0);
        expect_reg(1, 4'd0, 0);

        // R13: host writes call registers
        host_write(4'd0, 32'h11);
        host_write(4'd1, 32'h22);
        host_write(4'd2, 32'h33);
        host_write(4'd3, 32'h44);
        host_write(4'd4, 32'h1000);
        host_write(4'd5, 32'h100);
        expect_reg(13, 4'd0, 32'h11);
        expect_reg(13, 4'd3, 32'h44);
        expect_reg(13, 4'd4, 32'h1000);
        expect_reg(13, 4'd5, 32'h100);
        // R13: unit port ignored while no unit runs
        unit_wr(0, 32'hDEAD);
        expect_reg(13, 4'd0, 32'h11);

        // R2: host starts unit 2
        host_write(4'd8, 2);
        expect_sig(2, OBS_EN, 32'h4);
        expect_sig(2, OBS_IRQ, 0);

        // R13: running unit writes argument 1
        unit_wr(1, 32'hAAAA);
        expect_reg(13, 4'd1, 32'hAAAA);

        // R12: idle units' requests ignored
        unit_req(0, 1'b0, 3);
        expect_sig(12, OBS_EN, 32'h4);
        unit_done(1);
        expect_sig(12, OBS_EN, 32'h4);

        // R6 / R11: unit 2 calls unit 3
        unit_wr(5, 32'h200);
        unit_req(2, 1'b0, 3);
        expect_sig(6, OBS_EN, 32'h8);
        expect_sig(11, OBS_EN, 32'h8);
        expect_sig(6, OBS_IRQ, 0);

        // R7: unit 3 returns to unit 2
        unit_wr(6, 32'h55);
        unit_wr(5, 32'h300);
        unit_done(3);
        expect_sig(7, OBS_EN, 32'h4);
        expect_sig(7, OBS_IRQ, 0);
        expect_sig(7, OBS_RET, 32'h55);
        expect_sig(7, OBS_LR, 32'h200);

        // R4: unit 2 calls software routine 0x5A
        unit_req(2, 1'b1, 8'h5A);
        expect_sig(4, OBS_EN, 0);
        expect_sig(4, OBS_IRQ, 1);
        expect_reg(4, 4'd11, 32'h5A05);

        // R8: interrupt held until acknowledge
        repeat (3) tick();
        expect_sig(8, OBS_IRQ, 1);
        host_write(4'd10, 0);
        expect_sig(8, OBS_IRQ, 0);
        expect_reg(8, 4'd11, 32'h5A04);

        // R2 / R10: nested host call to unit 1 while serving unit 2
        host_write(4'd5, 32'h400);
        host_write(4'd8, 1);
        expect_sig(2, OBS_EN, 32'h2);

        // R3: unit 1 finishes back to software
        unit_done(1);
        expect_sig(3, OBS_EN, 0);
        expect_sig(3, OBS_IRQ, 1);
        expect_sig(3, OBS_LR, 32'h400);
        expect_reg(3, 4'd11, 32'h5A03);
        host_write(4'd10, 0);

        // R5: software routine finished, unit 2 resumes
        host_write(4'd9, 32'h77);
        expect_sig(5, OBS_EN, 32'h4);
        expect_sig(5, OBS_RET, 32'h77);
        expect_sig(5, OBS_LR, 32'h200);
        expect_sig(5, OBS_IRQ, 0);

        // R3: unit 2 finishes to the original software caller
        unit_done(2);
        expect_sig(3, OBS_EN, 0);
        expect_sig(3, OBS_IRQ, 1);
        expect_sig(3, OBS_LR, 32'h100);
        host_write(4'd10, 0);

        // R12: routine-finished write outside HOST_RUN ignored
        host_write(4'd9, 32'h99);
        expect_sig(12, OBS_RET, 32'h77);
        expect_sig(12, OBS_EN, 0);

        // R10 / R9: recursion to full depth, then overflow
        host_write(4'd8, 0);
        expect_sig(10, OBS_EN, 32'h1);
        for (int k = 1; k <= 15; k++) begin
            unit_wr(5, 32'(k));
            unit_req(0, 1'b0, 0);
            expect_sig(10, OBS_EN, 32'h1);
        end
        expect_reg(9, 4'd11, 32'h5A02);
        unit_wr(5, 32'd16);
        unit_req(0, 1'b0, 0);
        expect_sig(9, OBS_EN, 32'h1);
        expect_sig(9, OBS_IRQ, 0);
        expect_reg(9, 4'd11, 32'h5A0A);
        for (int k = 15; k >= 1; k--) begin
            unit_done(0);
            expect_sig(10, OBS_EN, 32'h1);
            expect_sig(10, OBS_LR, 32'(k));
        end
        unit_done(0);
        expect_sig(10, OBS_EN, 0);
        expect_sig(10, OBS_IRQ, 1);
        expect_sig(10, OBS_LR, 32'h100);
        expect_reg(9, 4'd11, 32'h5A0B);

        tick();
        tick();
        finished = 1'b1;
        summary();
    end

endmodule